// File: doc/BRIEF.md
# Two-Channel Distributed-Arithmetic Wavelet Analysis Stage

This block computes one analysis level of a one-dimensional discrete wavelet transform without multipliers. Signed samples arrive one at a time with a valid strobe and shift into an eight-entry window. After every second accepted sample the block runs a bit-serial pass over the window. In each cycle of the pass it gathers the same bit from every window sample into a table address. A low-pass table and a high-pass table each return a precomputed partial sum of their integer coefficients for that address. Each returned word is weighted by its bit position and added into an accumulator.

The two accumulators deliver an approximation and a detail coefficient together, one pair per two input samples. While a pass runs, the block reports itself busy and withdraws its ready signal. The upstream source must hold further samples until ready returns. The coefficient sets are the scaled and rounded 8-tap orthogonal pair given in R3 and R4.

Top module: `dwt_da_stage`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `busy` are 0, `in_ready` is 1, and `approx_out` and `detail_out` are 0.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Only the 2nd, 4th, 6th, ... accepted sample since reset starts a pass and leads to an output pair.
- R3: With w[0] the newest accepted sample and w[k] the one accepted k samples earlier (entries before the first sample are 0), `approx_out` equals the sum over k of L[k]*w[k], with L = {-1, 4, 4, -24, -4, 81, 92, 29} for k = 0..7.
- R4: `detail_out` equals the sum over k of H[k]*w[k], with H = {29, -92, 81, 4, -24, -4, 4, 1} for k = 0..7.
- R5: Samples are 8-bit two's complement. The full range from -128 to 127 in every window position gives the exact signed sums of R3 and R4.
- R6: `busy` rises on the edge that accepts an even-numbered sample and stays high for exactly 8 cycles. `in_ready` is 0 in exactly those cycles.
- R7: `out_valid` is high for exactly one cycle, starting on the edge that ends the pass, which is 8 edges after the accepting edge. `approx_out` and `detail_out` change only in that cycle and hold their values otherwise.
- R8: A sample offered while `busy` is 1 is not accepted. It never enters the window, and the window contents are unchanged at the end of the pass.
- R9: Accepting an odd-numbered sample does not raise `busy` and leaves `in_ready` at 1 and `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_sample | input | 8 | Two's-complement input sample |
| in_ready | output | 1 | The block can take a sample |
| busy | output | 1 | A bit-serial pass is running |
| out_valid | output | 1 | One-cycle strobe for a new output pair |
| approx_out | output | 18 | Low-pass (approximation) coefficient |
| detail_out | output | 18 | High-pass (detail) coefficient |

## Verification
The hardest case to reach is a sample that is offered while a pass is running and then withdrawn. The bench keeps `in_valid` high with junk data for several busy cycles and drops it before ready returns. It then checks that later output pairs match a window that never held the junk. Two's-complement weighting of the top bit is stressed with windows of all -128 and all 127. These windows drive the partial-sum words to their extremes and make the subtracted last term dominate.

// File: rtl/dwt_da_pkg.sv
// Package: shared constants for the wavelet DA stage.
// Holds the default integer coefficient sets (scale 128, rounded) for the
// low-pass and high-pass analysis filters; index 0 weights the newest sample.
package dwt_da_pkg;
    localparam int DEF_TAPS = 8;
    localparam int LP_COEF [DEF_TAPS] = '{-1, 4, 4, -24, -4, 81, 92, 29};
    localparam int HP_COEF [DEF_TAPS] = '{29, -92, 81, 4, -24, -4, 4, 1};
endpackage

// File: rtl/da_rom.sv
// Module: da_rom
// Partial-sum table for one filter. Entry a is the sum of the coefficients
// whose tap bit is set in a. The contents are computed at elaboration.
// Assumes every subset sum fits in ROM_W signed bits.
module da_rom #(
    parameter int TAPS  = 8,
    parameter int ROM_W = 9,
    parameter int COEF [TAPS] = dwt_da_pkg::LP_COEF
) (
    input  logic [TAPS-1:0]         addr,
    output logic signed [ROM_W-1:0] word
);
    localparam int DEPTH = 2 ** TAPS;

    // Sum of the selected coefficients for one address
    function automatic int subset_sum(input int a);
        int s = 0;
        for (int k = 0; k < TAPS; k++)
            if (((a >> k) & 1) == 1) s += COEF[k];
        return s;
    endfunction

    logic signed [ROM_W-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam logic signed [ROM_W-1:0] VAL = ROM_W'(subset_sum(a));
        // Constant table entry
        assign tbl[a] = VAL;
    end

    // Table lookup
    assign word = tbl[addr];
endmodule

// File: rtl/da_ctrl.sv
// Module: da_ctrl
// Holds the sample window, the accept-parity and the bit-serial schedule.
// It forms the bit-slice address for the current bit position.
// The window is frozen while a pass runs, so in_ready is low then.
module da_ctrl #(
    parameter int TAPS     = 8,
    parameter int SAMPLE_W = 8,
    localparam int BIT_W   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                in_ready,
    output logic                busy,
    output logic                start,
    output logic                last,
    output logic [BIT_W-1:0]    bit_idx,
    output logic [TAPS-1:0]     addr
);
    logic [SAMPLE_W-1:0] win [TAPS];
    logic                odd_seen;
    logic                accept;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;
    assign start    = accept && odd_seen;
    assign last     = busy && (bit_idx == BIT_W'(SAMPLE_W - 1));

    // Window entry 0 takes each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)      win[0] <= '0;
        else if (accept) win[0] <= in_sample;
    end

    for (genvar k = 1; k < TAPS; k++) begin : g_win
        // Shift older samples one place on each accept
        always_ff @(posedge clk) begin
            if (!rst_n)      win[k] <= '0;
            else if (accept) win[k] <= win[k-1];
        end
        assign addr[k] = win[k][bit_idx];
    end
    assign addr[0] = win[0][bit_idx];

    // Parity of accepts and the bit-serial pass schedule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_seen <= 1'b0;
            busy     <= 1'b0;
            bit_idx  <= '0;
        end else if (accept) begin
            odd_seen <= !odd_seen;
            if (odd_seen) begin
                busy    <= 1'b1;
                bit_idx <= '0;
            end
        end else if (busy) begin
            if (last) busy    <= 1'b0;
            else      bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/da_accum.sv
// Module: da_accum
// Shift-accumulate for one filter. Each table word is weighted by 2^bit.
// The top bit position is subtracted, as two's complement requires.
// The finished sum is registered at the end of the pass and held.
module da_accum #(
    parameter int SAMPLE_W = 8,
    parameter int ROM_W    = 9,
    parameter int ACC_W    = 18,
    localparam int BIT_W   = $clog2(SAMPLE_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    step,
    input  logic                    last,
    input  logic [BIT_W-1:0]        bit_idx,
    input  logic signed [ROM_W-1:0] word,
    output logic signed [ACC_W-1:0] result
);
    logic signed [ACC_W-1:0] acc, ext, shifted, term;

    // Weight and sign the current table word
    always_comb begin
        ext     = ACC_W'(word);
        shifted = ext <<< bit_idx;
        term    = last ? -shifted : shifted;
    end

    // Running sum, cleared when a pass starts
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (start) acc <= '0;
        else if (step)  acc <= acc + term;
    end

    // Result register, loaded with the final sum
    always_ff @(posedge clk) begin
        if (!rst_n)             result <= '0;
        else if (step && last)  result <= acc + term;
    end
endmodule

// File: rtl/dwt_da_stage.sv
// Module: dwt_da_stage (top)
// One analysis level of a 1-D wavelet transform done with distributed
// arithmetic. One window feeds a low-pass and a high-pass table. Both share
// one bit-serial schedule, and every second accepted sample yields a pair.
// Assumes ACC_W holds ROM_W + SAMPLE_W bits of signed growth.
module dwt_da_stage #(
    parameter int TAPS     = dwt_da_pkg::DEF_TAPS,
    parameter int SAMPLE_W = 8,
    parameter int ROM_W    = 9,
    parameter int LP_C [TAPS] = dwt_da_pkg::LP_COEF,
    parameter int HP_C [TAPS] = dwt_da_pkg::HP_COEF,
    localparam int ACC_W   = ROM_W + SAMPLE_W + 1,
    localparam int BIT_W   = $clog2(SAMPLE_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    output logic                    in_ready,
    output logic                    busy,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] approx_out,
    output logic signed [ACC_W-1:0] detail_out
);
    logic                    start, last;
    logic [BIT_W-1:0]        bit_idx;
    logic [TAPS-1:0]         addr;
    logic signed [ROM_W-1:0] lp_word, hp_word;

    da_ctrl #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .busy(busy), .start(start), .last(last),
        .bit_idx(bit_idx), .addr(addr)
    );

    da_rom #(.TAPS(TAPS), .ROM_W(ROM_W), .COEF(LP_C)) u_lp_rom (
        .addr(addr), .word(lp_word)
    );
    da_rom #(.TAPS(TAPS), .ROM_W(ROM_W), .COEF(HP_C)) u_hp_rom (
        .addr(addr), .word(hp_word)
    );

    da_accum #(.SAMPLE_W(SAMPLE_W), .ROM_W(ROM_W), .ACC_W(ACC_W)) u_lp_acc (
        .clk(clk), .rst_n(rst_n), .start(start), .step(busy), .last(last),
        .bit_idx(bit_idx), .word(lp_word), .result(approx_out)
    );
    da_accum #(.SAMPLE_W(SAMPLE_W), .ROM_W(ROM_W), .ACC_W(ACC_W)) u_hp_acc (
        .clk(clk), .rst_n(rst_n), .start(start), .step(busy), .last(last),
        .bit_idx(bit_idx), .word(hp_word), .result(detail_out)
    );

    // Output strobe for the cycle after the final bit
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= busy && last;
    end
endmodule

// File: rtl/dwt_da_stage_chk.sv
// Module: dwt_da_stage_chk
// Port-level protocol checks for dwt_da_stage. It is bound to every instance.
module dwt_da_stage_chk #(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             busy,
    input logic             out_valid,
    input logic [ACC_W-1:0] approx_out,
    input logic [ACC_W-1:0] detail_out
);
    localparam int CNT_W = $clog2(SAMPLE_W) + 2;
    logic             par;
    logic [CNT_W-1:0] busy_cnt;

    // Accept parity and busy-run length as seen at the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par      <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (in_valid && in_ready) par <= !par;
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
        end
    end

    // R2
    even_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && par) |=> busy);
    // R9
    odd_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !par) |=> !busy);
    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CNT_W'(SAMPLE_W)));
    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R7
    out_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(approx_out) && $stable(detail_out)));
endmodule

bind dwt_da_stage dwt_da_stage_chk #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .out_valid(out_valid), .approx_out(approx_out),
    .detail_out(detail_out)
);

// File: tb/dwt_da_stage_bench.sv
// Directed bench for dwt_da_stage: one task per scenario.
module dwt_da_stage_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_sample = '0;
    logic              in_ready, busy, out_valid;
    logic signed [17:0] approx_out, detail_out;

    int n_chk = 0;
    int n_fail = 0;
    int n_acc = 0;
    int hist [8];
    int lp [8] = '{-1, 4, 4, -24, -4, 81, 92, 29};
    int hp [8] = '{29, -92, 81, 4, -24, -4, 4, 1};

    always #5 clk = ~clk;

    dwt_da_stage u_dwt_da_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .busy(busy), .out_valid(out_valid),
        .approx_out(approx_out), .detail_out(detail_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dot(input bit high);
        int s = 0;
        for (int k = 0; k < 8; k++) s += (high ? hp[k] : lp[k]) * hist[k];
        return s;
    endfunction

    // Present one sample and check the schedule; junk_cycles > 0 offers
    // junk while busy and withdraws it before ready returns.
    task automatic send(input int v, input int junk_cycles);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'(v);
        @(posedge clk);
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
        n_acc++;
        @(negedge clk);
        in_valid = 1'b0;
        if (n_acc % 2 == 1) begin
            check("R9 busy after odd", int'(busy), 0);
            check("R9 ready after odd", int'(in_ready), 1);
        end else begin
            check("R6 busy after even", int'(busy), 1);
            check("R6 ready low", int'(in_ready), 0);
            for (int c = 1; c < 8; c++) begin
                if (c <= junk_cycles) begin
                    in_valid  = 1'b1;
                    in_sample = 8'h5A;
                end else in_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R7 no early valid", int'(out_valid), 0);
                check("R6 busy held", int'(busy), 1);
            end
            in_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R7 valid at end", int'(out_valid), 1);
            check("R6 ready back", int'(in_ready), 1);
            check("R3 approx", int'(approx_out), dot(1'b0));
            check("R4 detail", int'(detail_out), dot(1'b1));
            @(posedge clk);
            @(negedge clk);
            check("R7 single pulse", int'(out_valid), 0);
            check("R7 approx held", int'(approx_out), dot(1'b0));
        end
    endtask

    task automatic t_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 approx", int'(approx_out), 0);
        check("R1 detail", int'(detail_out), 0);
    endtask

    task automatic t_impulse();
        // R2 R3 R4: a unit impulse walks through the window
        send(1, 0);
        for (int i = 0; i < 9; i++) send(0, 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 10; i++) send(i * 13 - 60, 0);
    endtask

    task automatic t_extremes();
        // R5: the top bit must carry negative weight
        for (int i = 0; i < 8; i++) send(-128, 0);
        for (int i = 0; i < 8; i++) send(127, 0);
        for (int i = 0; i < 8; i++) send((i % 2) ? 127 : -128, 0);
    endtask

    task automatic t_backpressure();
        // R8: junk offered during busy never enters the window
        send(37, 0);
        send(-90, 5);
        send(11, 0);
        send(64, 7);
        send(-3, 0);
        send(100, 0);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) hist[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_impulse();
        t_ramp();
        t_extremes();
        t_backpressure();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule